// File: doc/BRIEF.md
# Two-Channel Word DMA for a Serial Port

This block moves words between a serial port and system memory without processor help. It has two independent channels. The receive channel writes each incoming word to memory. The transmit channel reads each outgoing word from memory. Software sets up each channel through a small register port. It gives the channel a word-aligned byte address, called the pointer, and a number of words to move, called the count.

A channel starts a transfer when its peripheral flag is high and its count is not zero. The flag is "receive word available" for the receive channel and "transmit holding empty" for the transmit channel. Both channels share one single-word memory port, and only one request is open at a time. When memory acknowledges the request, the channel steps its pointer forward by one word and decrements its count. The same acknowledge cycle also tells the peripheral that its flag has been used.

When a count reaches zero, the channel raises its end flag and stops. The end flag can be routed to the interrupt output. Loading a nonzero count restarts the channel.

Top module: `ptr_dma_pair`

## Requirements
- R1: After reset, both pointers and both counts read as 0, `rx_end` and `tx_end` are 1, `irq` is 0 and `mem_req` is 0.
- R2: Receive transfer. When `rx_ready` is high and the receive count is nonzero, `mem_req` rises one cycle later with `mem_we`=1, `mem_addr` equal to the receive pointer and `mem_wdata` equal to `rx_data`.
- R3: Transmit transfer. When `tx_empty` is high and the transmit count is nonzero, a read request (`mem_we`=0) goes to the transmit pointer. In the acknowledge cycle, `tx_load` is 1 and `tx_data` equals `mem_rdata`.
- R4: Each acknowledged transfer adds 4 to that channel's pointer and subtracts 1 from its count. Both new values are visible from the cycle after the acknowledge.
- R5: When a count reaches 0, the channel's end flag is set from the next cycle. While the flag is set, the channel makes no memory request, whatever the state of its peripheral flag.
- R6: Writing a nonzero count clears the channel's end flag from the next cycle. Writing 0 sets it. A written value wider than the count field saturates to all ones.
- R7: Register address 4, bit 0, enables the receive interrupt; bit 1 enables the transmit interrupt. `irq` is the OR of each end flag ANDed with its enable.
- R8: When both channels are ready in the same cycle, the receive channel is served first. The transmit request follows after one idle cycle.
- R9: There is at most one open request. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`, and `mem_req` is low in the cycle after the acknowledge.
- R10: `rx_take` is high only in the acknowledge cycle of a receive transfer. `rx_take` and `tx_load` are never high together.

Register map, word select on `cfg_addr`:
- 0: receive pointer
- 1: receive count
- 2: transmit pointer
- 3: transmit count
- 4: interrupt enables

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rx_ready | input | 1 | Peripheral has a received word |
| rx_data | input | 32 | Received word |
| rx_take | output | 1 | Received word consumed |
| tx_empty | input | 1 | Peripheral can accept a word |
| tx_data | output | 32 | Word for the peripheral |
| tx_load | output | 1 | `tx_data` valid, load it |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed this cycle |
| rx_end | output | 1 | Receive count at zero |
| tx_end | output | 1 | Transmit count at zero |
| irq | output | 1 | Interrupt |

## Verification
Each result has a fixed due cycle, and the checks sample on that cycle:
- A memory request appears one clock edge after its flag is seen with a nonzero count.
- `rx_take` and `tx_load` appear in the same cycle as `mem_ack`, since they come straight from the acknowledge.
- Pointer, count, end flag and `irq` take their new values one edge after the acknowledge or register write.

The bench drives inputs on the falling edge and checks outputs half a cycle after the rising edge that should have changed them. For "nothing happens" cases, it holds a flag high for several cycles and checks that no request appears.

// File: rtl/ptr_dma_pkg.sv
package ptr_dma_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_RX   = 2'd1,
        ARB_TX   = 2'd2
    } arb_state_e;

    localparam int CH_RX  = 0;
    localparam int CH_TX  = 1;
    localparam int N_CH   = 2;

    localparam logic [2:0] REG_RX_PTR = 3'd0;
    localparam logic [2:0] REG_RX_CNT = 3'd1;
    localparam logic [2:0] REG_TX_PTR = 3'd2;
    localparam logic [2:0] REG_TX_CNT = 3'd3;
    localparam logic [2:0] REG_IE     = 3'd4;

endpackage

// File: rtl/ptr_dma_chan.sv
module ptr_dma_chan #(
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ptr,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          flag,
    input  logic          done,
    output logic          req,
    output logic [DW-1:0] ptr,
    output logic [CW-1:0] cnt,
    output logic          fin
);

    typedef struct packed {
        logic [DW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          fin;
    } chan_s;

    chan_s st_d, st_q;
    logic [CW-1:0] load_cnt;

    // Oversized count writes saturate so no written bit is silently dropped
    always_comb begin
        if (|wdata[DW-1:CW]) load_cnt = '1;
        else                 load_cnt = wdata[CW-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (wr_ptr)
            st_d.ptr = wdata;
        else if (done)
            st_d.ptr = st_q.ptr + DW'(STEP);

        // A register write wins over a completion in the same cycle
        if (wr_cnt) begin
            st_d.cnt = load_cnt;
            st_d.fin = (load_cnt == '0);
        end else if (done) begin
            st_d.cnt = st_q.cnt - CW'(1);
            st_d.fin = (st_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= '0;
            st_q.cnt <= '0;
            st_q.fin <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = flag && !st_q.fin;
    assign ptr = st_q.ptr;
    assign cnt = st_q.cnt;
    assign fin = st_q.fin;

endmodule

// File: rtl/ptr_dma_arb.sv
module ptr_dma_arb
    import ptr_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    req,
    input  logic [DW-1:0] ptr_rx,
    input  logic [DW-1:0] ptr_tx,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [1:0]    done
);

    typedef struct packed {
        arb_state_e st;
    } arb_s;

    arb_s a_d, a_q;

    always_comb begin
        a_d = a_q;
        unique case (a_q.st)
            ARB_IDLE: begin
                if (req[CH_RX])      a_d.st = ARB_RX;
                else if (req[CH_TX]) a_d.st = ARB_TX;
            end
            ARB_RX, ARB_TX: begin
                if (mem_ack) a_d.st = ARB_IDLE;
            end
            default: a_d.st = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q.st <= ARB_IDLE;
        else        a_q   <= a_d;
    end

    always_comb begin
        mem_req  = (a_q.st != ARB_IDLE);
        mem_we   = (a_q.st == ARB_RX);
        mem_addr = (a_q.st == ARB_TX) ? ptr_tx : ptr_rx;
        done[CH_RX] = mem_ack && (a_q.st == ARB_RX);
        done[CH_TX] = mem_ack && (a_q.st == ARB_TX);
    end

endmodule

// File: rtl/ptr_dma_pair.sv
module ptr_dma_pair
    import ptr_dma_pkg::*;
#(
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          rx_ready,
    input  logic [DW-1:0] rx_data,
    output logic          rx_take,
    input  logic          tx_empty,
    output logic [DW-1:0] tx_data,
    output logic          tx_load,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          rx_end,
    output logic          tx_end,
    output logic          irq
);

    localparam logic [2:0] PTR_SEL [N_CH] = '{REG_RX_PTR, REG_TX_PTR};
    localparam logic [2:0] CNT_SEL [N_CH] = '{REG_RX_CNT, REG_TX_CNT};

    typedef struct packed {
        logic [N_CH-1:0] ie;
    } top_s;

    top_s t_d, t_q;

    logic [N_CH-1:0] flag, done, req, fin;
    logic [DW-1:0]   ch_ptr [N_CH];
    logic [CW-1:0]   ch_cnt [N_CH];

    assign flag[CH_RX] = rx_ready;
    assign flag[CH_TX] = tx_empty;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        ptr_dma_chan #(.DW(DW), .CW(CW), .STEP(STEP)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ptr (cfg_we && (cfg_addr == PTR_SEL[i])),
            .wr_cnt (cfg_we && (cfg_addr == CNT_SEL[i])),
            .wdata  (cfg_wdata),
            .flag   (flag[i]),
            .done   (done[i]),
            .req    (req[i]),
            .ptr    (ch_ptr[i]),
            .cnt    (ch_cnt[i]),
            .fin    (fin[i])
        );
    end

    ptr_dma_arb #(.DW(DW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .ptr_rx   (ch_ptr[CH_RX]),
        .ptr_tx   (ch_ptr[CH_TX]),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .done     (done)
    );

    always_comb begin
        t_d = t_q;
        if (cfg_we && cfg_addr == REG_IE)
            t_d.ie = cfg_wdata[N_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q.ie <= '0;
        else        t_q    <= t_d;
    end

    always_comb begin
        unique case (cfg_addr)
            REG_RX_PTR: cfg_rdata = ch_ptr[CH_RX];
            REG_RX_CNT: cfg_rdata = DW'(ch_cnt[CH_RX]);
            REG_TX_PTR: cfg_rdata = ch_ptr[CH_TX];
            REG_TX_CNT: cfg_rdata = DW'(ch_cnt[CH_TX]);
            REG_IE:     cfg_rdata = DW'(t_q.ie);
            default:    cfg_rdata = '0;
        endcase
    end

    assign mem_wdata = rx_data;
    assign tx_data   = mem_rdata;
    assign rx_take   = done[CH_RX];
    assign tx_load   = done[CH_TX];
    assign rx_end    = fin[CH_RX];
    assign tx_end    = fin[CH_TX];
    assign irq       = |(fin & t_q.ie);

endmodule

// File: rtl/ptr_dma_chk.sv
module ptr_dma_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_take,
    input logic          tx_load,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          rx_end,
    input logic          tx_end,
    input logic          irq
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req); // R9

    AST_NO_RX_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end && !mem_req |=> !(mem_req && mem_we)); // R5

    AST_NO_TX_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end && !mem_req |=> !(mem_req && !mem_we)); // R5

    AST_TAKE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> mem_req && mem_ack && mem_we); // R10

    AST_LOAD_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> mem_req && mem_ack && !mem_we); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_take, tx_load})); // R10

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_end || tx_end); // R7

endmodule

bind ptr_dma_pair ptr_dma_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_take  (rx_take),
    .tx_load  (tx_load),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .rx_end   (rx_end),
    .tx_end   (tx_end),
    .irq      (irq)
);

// File: tb/sim_ptr_dma_pair.sv
`timescale 1ns/1ps
module sim_ptr_dma_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rx_ready = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_take;
    logic        tx_empty = 1'b0;
    logic [31:0] tx_data;
    logic        tx_load;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        rx_end, tx_end, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ptr_dma_pair u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_take(rx_take), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_load(tx_load), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .rx_end(rx_end),
        .tx_end(tx_end), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic t_reset();
        chk("R1 rx_end", 32'(rx_end), 1);
        chk("R1 tx_end", 32'(tx_end), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        rd("R1 rx ptr", 3'd0, 0);
        rd("R1 rx cnt", 3'd1, 0);
        rd("R1 tx ptr", 3'd2, 0);
        rd("R1 tx cnt", 3'd3, 0);
    endtask

    task automatic t_rx();
        wr(3'd0, 32'h100);
        wr(3'd1, 32'd2);
        chk("R6 rx_end cleared", 32'(rx_end), 0);
        for (int k = 0; k < 2; k++) begin
            rx_data = 32'hA500 + 32'(k);
            rx_ready = 1'b1;
            step();
            chk("R2 req", 32'(mem_req), 1);
            chk("R2 we", 32'(mem_we), 1);
            chk("R2 addr", mem_addr, 32'h100 + 32'(4*k));
            chk("R2 wdata", mem_wdata, 32'hA500 + 32'(k));
            step();
            step();
            chk("R9 still req", 32'(mem_req), 1);
            chk("R9 addr held", mem_addr, 32'h100 + 32'(4*k));
            mem_ack = 1'b1;
            #1;
            chk("R10 rx_take", 32'(rx_take), 1);
            step();
            mem_ack = 1'b0;
            rx_ready = 1'b0;
            #1;
            chk("R9 req dropped", 32'(mem_req), 0);
            chk("R10 take low", 32'(rx_take), 0);
            rd("R4 rx ptr", 3'd0, 32'h104 + 32'(4*k));
            rd("R4 rx cnt", 3'd1, 32'(1 - k));
        end
        chk("R5 rx_end set", 32'(rx_end), 1);
        rx_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R5 no req at end", 32'(mem_req), 0);
        end
        rx_ready = 1'b0;
        rd("R5 ptr unchanged", 3'd0, 32'h108);
    endtask

    task automatic t_tx();
        wr(3'd4, 32'd0);
        wr(3'd2, 32'h200);
        wr(3'd3, 32'd1);
        tx_empty = 1'b1;
        step();
        chk("R3 req", 32'(mem_req), 1);
        chk("R3 we", 32'(mem_we), 0);
        chk("R3 addr", mem_addr, 32'h200);
        mem_rdata = 32'hDEAD_BEEF;
        mem_ack = 1'b1;
        #1;
        chk("R3 tx_load", 32'(tx_load), 1);
        chk("R3 tx_data", tx_data, 32'hDEAD_BEEF);
        chk("R10 no rx_take", 32'(rx_take), 0);
        step();
        mem_ack = 1'b0;
        tx_empty = 1'b0;
        chk("R5 tx_end", 32'(tx_end), 1);
        rd("R4 tx ptr", 3'd2, 32'h204);
        chk("R7 irq masked", 32'(irq), 0);
        wr(3'd4, 32'd2);
        chk("R7 irq tx", 32'(irq), 1);
        wr(3'd3, 32'd5);
        chk("R7 irq cleared by reload", 32'(irq), 0);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        chk("R7 irq off", 32'(irq), 0);
    endtask

    task automatic t_reload();
        wr(3'd1, 32'd3);
        chk("R6 nonzero clears", 32'(rx_end), 0);
        wr(3'd1, 32'd0);
        chk("R6 zero sets", 32'(rx_end), 1);
        wr(3'd1, 32'h0001_0000);
        rd("R6 saturate", 3'd1, 32'h0000_FFFF);
        chk("R6 saturate clears", 32'(rx_end), 0);
        wr(3'd4, 32'd1);
        wr(3'd1, 32'd0);
        chk("R7 irq rx", 32'(irq), 1);
        wr(3'd4, 32'd0);
    endtask

    task automatic t_prio();
        wr(3'd0, 32'h300);
        wr(3'd1, 32'd1);
        wr(3'd2, 32'h400);
        wr(3'd3, 32'd1);
        rx_ready = 1'b1;
        tx_empty = 1'b1;
        step();
        chk("R8 rx first", 32'(mem_we), 1);
        chk("R8 rx addr", mem_addr, 32'h300);
        mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        rx_ready = 1'b0;
        chk("R8 idle gap", 32'(mem_req), 0);
        step();
        chk("R8 tx next", 32'(mem_req), 1);
        chk("R8 tx we", 32'(mem_we), 0);
        chk("R8 tx addr", mem_addr, 32'h400);
        mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        tx_empty = 1'b0;
        chk("R5 both ended", 32'({rx_end, tx_end}), 32'd3);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx();
        t_tx();
        t_reload();
        t_prio();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

endmodule